// File: doc/BRIEF.md
# Machine-Mode CSR File

This unit holds the machine-mode control and status registers of a small multi-cycle processor that runs only in machine mode. The core presents a 12-bit CSR number, one of three operations (replace, set bits, clear bits) and a write operand. The unit returns the old register value in the same cycle, and the new value takes effect at the next rising clock edge. In that same cycle it also reports whether the access is legal. The core turns an illegal result into an illegal-instruction exception.

The unit also keeps the trap state. When the core takes a trap, it pulses a trap strobe along with the cause and the faulting PC. To return, it pulses an mret strobe. The unit exports the trap vector, the return PC and an interrupt-pending flag, which is gated by the global and per-source enables. Only a small set of bits exists physically. Counters and identity registers read as zero. Unimplemented addresses, and writes to identity registers, are flagged as illegal.

Top module: `mcsr_unit`

## Requirements
- R1: Operation code 2'b01 replaces the register, 2'b10 ORs the operand in, and 2'b11 clears the operand's set bits (code 2'b00 performs no write). `csr_rdata` shows the value from before the access, and the update is visible after the next rising edge. mscratch (0x340) keeps all 32 bits.
- R2: mepc (0x341) and mtvec (0x305) read with bits 1:0 forced to zero. `trap_vector` equals the mtvec read value, and `return_pc` equals the mepc read value.
- R3: mstatus (0x300) holds only MIE (bit 3) and MPIE (bit 7). MPP (bits 12:11) always reads 2'b11. mie (0x304) holds only bit 11. All other bits of both registers read zero, and the reset value of mstatus is 0x00001800.
- R4: mip (0x344) reads `ext_irq` at bit 11 and zero elsewhere. Writes to it are legal and change nothing.
- R5: misa, mstatush, mcountinhibit, mtval, mcycle, minstret, their upper halves (0xB80, 0xB82), the event selectors 0x323-0x33F and the counters 0xB03-0xB1F/0xB83-0xB9F read zero. Writes to them are legal and are discarded.
- R6: The identity group 0xF11-0xF15 reads zero, and any access to it that intends to write is illegal.
- R7: When `csr_en` is high, every other address (for example delegation, counter-enable, environment-config and security-config registers) is illegal. When `csr_en` is low, `csr_illegal` is 0.
- R8: Set or clear with a zero operand carries no write intent. It is therefore legal on every implemented address, including the identity group.
- R9: On `trap_take`, MPIE takes the old MIE, MIE clears, mepc loads `trap_pc`, and mcause loads `{trap_irq, 0..., trap_code}`, so bit 31 marks an interrupt.
- R10: On `mret_take`, MIE takes MPIE, MPIE sets to 1, MPP stays 2'b11, and mepc is unchanged.
- R11: `irq_pending` is high exactly when `ext_irq`, mie bit 11 and mstatus MIE are all 1.
- R12: In a given cycle a trap takes precedence over mret, and both take precedence over a CSR write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| csr_en | input | 1 | A CSR access is presented this cycle |
| csr_addr | input | 12 | CSR number |
| csr_op | input | 2 | 01 replace, 10 set, 11 clear, 00 none |
| csr_wdata | input | 32 | Write operand / bit mask |
| csr_rdata | output | 32 | Current value of the addressed CSR |
| csr_illegal | output | 1 | Access must raise illegal instruction |
| trap_take | input | 1 | Trap entry strobe |
| trap_irq | input | 1 | Trap is an interrupt |
| trap_code | input | 4 | Exception or interrupt code |
| trap_pc | input | 32 | PC to save in mepc |
| mret_take | input | 1 | Return-from-trap strobe |
| ext_irq | input | 1 | External interrupt level |
| irq_pending | output | 1 | Enabled external interrupt pending |
| trap_vector | output | 32 | Handler address |
| return_pc | output | 32 | mret target |

## Verification
The bench focuses on the boundary between legal and illegal. It issues set and clear operations with a zero operand to the identity group, which a design that treats every set or clear as a write would flag as illegal. It issues writes to the counters, which a design that merges the two read-zero groups would trap. It also probes the unlisted addresses at the edges of the implemented ranges, which a design with loose decoding would accept. It drives a trap in the same cycle as a CSR write to mepc: a design with the wrong precedence would keep the software value. It then runs two trap/mret round trips, one with MIE set and one with it clear. These catch swapped MIE/MPIE handling, which shows up as a wrong mstatus value or a spurious `irq_pending`.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    // Storage class of an address, chosen by the decoder.
    typedef enum logic [3:0] {
        CLS_STATUS,
        CLS_IE,
        CLS_TVEC,
        CLS_SCRATCH,
        CLS_EPC,
        CLS_CAUSE,
        CLS_IP,
        CLS_ZERO,
        CLS_IDENT,
        CLS_NONE
    } csr_cls_e;

    localparam int ADDR_W   = 12;
    localparam int MIE_BIT  = 3;
    localparam int MPIE_BIT = 7;
    localparam int MPP_LO   = 11;
    localparam int MPP_HI   = 12;
    localparam int MEI_BIT  = 11;

    localparam logic [ADDR_W-1:0] A_STATUS   = 12'h300;
    localparam logic [ADDR_W-1:0] A_ISA      = 12'h301;
    localparam logic [ADDR_W-1:0] A_IE       = 12'h304;
    localparam logic [ADDR_W-1:0] A_TVEC     = 12'h305;
    localparam logic [ADDR_W-1:0] A_STATUSH  = 12'h310;
    localparam logic [ADDR_W-1:0] A_CNTINH   = 12'h320;
    localparam logic [ADDR_W-1:0] A_EVT_LO   = 12'h323;
    localparam logic [ADDR_W-1:0] A_EVT_HI   = 12'h33F;
    localparam logic [ADDR_W-1:0] A_SCRATCH  = 12'h340;
    localparam logic [ADDR_W-1:0] A_EPC      = 12'h341;
    localparam logic [ADDR_W-1:0] A_CAUSE    = 12'h342;
    localparam logic [ADDR_W-1:0] A_TVAL     = 12'h343;
    localparam logic [ADDR_W-1:0] A_IP       = 12'h344;
    localparam logic [ADDR_W-1:0] A_CYC      = 12'hB00;
    localparam logic [ADDR_W-1:0] A_RET      = 12'hB02;
    localparam logic [ADDR_W-1:0] A_CNT_LO   = 12'hB03;
    localparam logic [ADDR_W-1:0] A_CNT_HI   = 12'hB1F;
    localparam logic [ADDR_W-1:0] A_CYCH     = 12'hB80;
    localparam logic [ADDR_W-1:0] A_RETH     = 12'hB82;
    localparam logic [ADDR_W-1:0] A_CNTH_LO  = 12'hB83;
    localparam logic [ADDR_W-1:0] A_CNTH_HI  = 12'hB9F;
    localparam logic [ADDR_W-1:0] A_IDENT_LO = 12'hF11;
    localparam logic [ADDR_W-1:0] A_IDENT_HI = 12'hF15;

    // Set/clear with an all-zero mask is a pure read.
    function automatic logic op_intends_write(csr_op_e op, logic operand_nonzero);
        case (op)
            OP_WRITE:          return 1'b1;
            OP_SET, OP_CLEAR:  return operand_nonzero;
            default:           return 1'b0;
        endcase
    endfunction

    function automatic logic in_span(logic [ADDR_W-1:0] a,
                                     logic [ADDR_W-1:0] lo,
                                     logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
    import mcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                  csr_en,
    input  logic [ADDR_W-1:0]     csr_addr,
    input  csr_op_e               csr_op,
    input  logic [XLEN-1:0]       csr_wdata,
    output csr_cls_e              cls,
    output logic                  wr_en,
    output logic                  illegal
);

    logic intent;

    always_comb begin
        cls = CLS_NONE;
        case (csr_addr)
            A_STATUS:  cls = CLS_STATUS;
            A_IE:      cls = CLS_IE;
            A_TVEC:    cls = CLS_TVEC;
            A_SCRATCH: cls = CLS_SCRATCH;
            A_EPC:     cls = CLS_EPC;
            A_CAUSE:   cls = CLS_CAUSE;
            A_IP:      cls = CLS_IP;
            A_ISA, A_STATUSH, A_CNTINH, A_TVAL,
            A_CYC, A_RET, A_CYCH, A_RETH:
                       cls = CLS_ZERO;
            default: begin
                if (in_span(csr_addr, A_EVT_LO, A_EVT_HI) ||
                    in_span(csr_addr, A_CNT_LO, A_CNT_HI) ||
                    in_span(csr_addr, A_CNTH_LO, A_CNTH_HI))
                    cls = CLS_ZERO;
                else if (in_span(csr_addr, A_IDENT_LO, A_IDENT_HI))
                    cls = CLS_IDENT;
            end
        endcase
    end

    assign intent  = op_intends_write(csr_op, |csr_wdata);
    assign illegal = csr_en && ((cls == CLS_NONE) || ((cls == CLS_IDENT) && intent));
    assign wr_en   = csr_en && intent && !illegal;

endmodule

// File: rtl/mcsr_regs.sv
module mcsr_regs
    import mcsr_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  csr_cls_e            cls,
    input  logic                wr_en,
    input  csr_op_e             op,
    input  logic [XLEN-1:0]     wdata,
    input  logic                trap_take,
    input  logic                trap_irq,
    input  logic [CAUSE_W-1:0]  trap_code,
    input  logic [XLEN-1:0]     trap_pc,
    input  logic                mret_take,
    input  logic                ext_irq,
    output logic [XLEN-1:0]     rdata,
    output logic                irq_pending,
    output logic [XLEN-1:0]     trap_vector,
    output logic [XLEN-1:0]     return_pc
);

    localparam logic [XLEN-1:0] ALIGN_MASK = {{(XLEN-2){1'b1}}, 2'b00};
    localparam int              CAUSE_PAD  = XLEN - 1 - CAUSE_W;

    logic [XLEN-1:0] scratch_q, epc_q, cause_q, tvec_q;
    logic            st_mie_q, st_mpie_q, ie_mei_q;
    logic [XLEN-1:0] status_w, ie_w, ip_w, nxt;

    always_comb begin
        status_w                 = '0;
        status_w[MPP_HI:MPP_LO]  = 2'b11;
        status_w[MIE_BIT]        = st_mie_q;
        status_w[MPIE_BIT]       = st_mpie_q;
        ie_w                     = '0;
        ie_w[MEI_BIT]            = ie_mei_q;
        ip_w                     = '0;
        ip_w[MEI_BIT]            = ext_irq;
    end

    always_comb begin
        case (cls)
            CLS_STATUS:  rdata = status_w;
            CLS_IE:      rdata = ie_w;
            CLS_IP:      rdata = ip_w;
            CLS_TVEC:    rdata = tvec_q & ALIGN_MASK;
            CLS_SCRATCH: rdata = scratch_q;
            CLS_EPC:     rdata = epc_q & ALIGN_MASK;
            CLS_CAUSE:   rdata = cause_q;
            default:     rdata = '0;
        endcase
    end

    always_comb begin
        case (op)
            OP_WRITE: nxt = wdata;
            OP_SET:   nxt = rdata | wdata;
            OP_CLEAR: nxt = rdata & ~wdata;
            default:  nxt = rdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch_q <= '0;
            epc_q     <= '0;
            cause_q   <= '0;
            tvec_q    <= '0;
            st_mie_q  <= 1'b0;
            st_mpie_q <= 1'b0;
            ie_mei_q  <= 1'b0;
        end else if (trap_take) begin
            st_mpie_q <= st_mie_q;
            st_mie_q  <= 1'b0;
            epc_q     <= trap_pc;
            cause_q   <= {trap_irq, {CAUSE_PAD{1'b0}}, trap_code};
        end else if (mret_take) begin
            st_mie_q  <= st_mpie_q;
            st_mpie_q <= 1'b1;
        end else if (wr_en) begin
            case (cls)
                CLS_STATUS: begin
                    st_mie_q  <= nxt[MIE_BIT];
                    st_mpie_q <= nxt[MPIE_BIT];
                end
                CLS_IE:      ie_mei_q  <= nxt[MEI_BIT];
                CLS_TVEC:    tvec_q    <= nxt;
                CLS_SCRATCH: scratch_q <= nxt;
                CLS_EPC:     epc_q     <= nxt;
                CLS_CAUSE:   cause_q   <= nxt;
                default: ;
            endcase
        end
    end

    assign irq_pending = ext_irq && ie_mei_q && st_mie_q;
    assign trap_vector = tvec_q & ALIGN_MASK;
    assign return_pc   = epc_q & ALIGN_MASK;

    // R9
    trap_masks_irq_chk: assert property (@(posedge clk) disable iff (rst)
        trap_take |=> !irq_pending);

    // R9
    trap_saves_pc_chk: assert property (@(posedge clk) disable iff (rst)
        trap_take |=> (return_pc == ($past(trap_pc) & ALIGN_MASK)));

    // R10
    mret_keeps_epc_chk: assert property (@(posedge clk) disable iff (rst)
        (mret_take && !trap_take) |=> $stable(return_pc));

endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
    import mcsr_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                csr_en,
    input  logic [11:0]         csr_addr,
    input  logic [1:0]          csr_op,
    input  logic [XLEN-1:0]     csr_wdata,
    output logic [XLEN-1:0]     csr_rdata,
    output logic                csr_illegal,
    input  logic                trap_take,
    input  logic                trap_irq,
    input  logic [CAUSE_W-1:0]  trap_code,
    input  logic [XLEN-1:0]     trap_pc,
    input  logic                mret_take,
    input  logic                ext_irq,
    output logic                irq_pending,
    output logic [XLEN-1:0]     trap_vector,
    output logic [XLEN-1:0]     return_pc
);

    csr_op_e  op;
    csr_cls_e cls;
    logic     wr_en;

    assign op = csr_op_e'(csr_op);

    mcsr_decode #(.XLEN(XLEN)) decode_i (
        .csr_en    (csr_en),
        .csr_addr  (csr_addr),
        .csr_op    (op),
        .csr_wdata (csr_wdata),
        .cls       (cls),
        .wr_en     (wr_en),
        .illegal   (csr_illegal)
    );

    mcsr_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) regs_i (
        .clk         (clk),
        .rst         (rst),
        .cls         (cls),
        .wr_en       (wr_en),
        .op          (op),
        .wdata       (csr_wdata),
        .trap_take   (trap_take),
        .trap_irq    (trap_irq),
        .trap_code   (trap_code),
        .trap_pc     (trap_pc),
        .mret_take   (mret_take),
        .ext_irq     (ext_irq),
        .rdata       (csr_rdata),
        .irq_pending (irq_pending),
        .trap_vector (trap_vector),
        .return_pc   (return_pc)
    );

    // R11
    irq_needs_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pending |-> ext_irq);

    // R8
    zero_mask_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_en && (op == OP_SET || op == OP_CLEAR) && csr_wdata == '0 && cls != CLS_NONE)
            |-> !csr_illegal);

    // R7
    idle_never_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        !csr_en |-> !csr_illegal);

endmodule

// File: tb/mcsr_unit_tb_top.sv
module mcsr_unit_tb_top;

    typedef struct packed {
        logic [31:0] rdata;
        logic        ill;
        logic        irq;
        logic [31:0] vec;
        logic [31:0] ret;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_en = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [1:0]  csr_op = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        csr_illegal;
    logic        trap_take = 1'b0;
    logic        trap_irq = 1'b0;
    logic [3:0]  trap_code = '0;
    logic [31:0] trap_pc = '0;
    logic        mret_take = 1'b0;
    logic        ext_irq = 1'b0;
    logic        irq_pending;
    logic [31:0] trap_vector;
    logic [31:0] return_pc;

    exp_t  sb_q[$];
    string tag_q[$];
    logic  chk_valid = 1'b0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;

    logic        e_irq = 1'b0;
    logic [31:0] e_vec = '0;
    logic [31:0] e_ret = '0;

    localparam logic [1:0] WR = 2'b01, ST = 2'b10, CL = 2'b11;

    always #5 clk = ~clk;

    mcsr_unit dut_i (
        .clk(clk), .rst(rst), .csr_en(csr_en), .csr_addr(csr_addr),
        .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .trap_take(trap_take), .trap_irq(trap_irq),
        .trap_code(trap_code), .trap_pc(trap_pc), .mret_take(mret_take),
        .ext_irq(ext_irq), .irq_pending(irq_pending),
        .trap_vector(trap_vector), .return_pc(return_pc)
    );

    // Monitor: compare each observed access against the scoreboard head.
    always @(negedge clk) begin
        #2;
        if (chk_valid && sb_q.size() > 0) begin
            exp_t  e;
            string t;
            e = sb_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (csr_rdata !== e.rdata || csr_illegal !== e.ill || irq_pending !== e.irq ||
                trap_vector !== e.vec || return_pc !== e.ret) begin
                n_bad++;
                $display("FAIL %s: got rdata=%h ill=%b irq=%b vec=%h ret=%h, exp rdata=%h ill=%b irq=%b vec=%h ret=%h",
                         t, csr_rdata, csr_illegal, irq_pending, trap_vector, return_pc,
                         e.rdata, e.ill, e.irq, e.vec, e.ret);
            end
        end
    end

    task automatic access(input logic [11:0] a, input logic [1:0] op, input logic [31:0] wd,
                          input logic en, input logic [31:0] erd, input logic eill,
                          input string t);
        exp_t e;
        @(negedge clk);
        csr_addr  = a;
        csr_op    = op;
        csr_wdata = wd;
        csr_en    = en;
        e.rdata = erd; e.ill = eill; e.irq = e_irq; e.vec = e_vec; e.ret = e_ret;
        sb_q.push_back(e);
        tag_q.push_back(t);
        chk_valid = 1'b1;
        @(posedge clk);
        #1;
        csr_en    = 1'b0;
        csr_op    = 2'b00;
        chk_valid = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] erd, input string t);
        access(a, ST, 32'h0, 1'b1, erd, 1'b0, t);
    endtask

    // Trap pulse; optionally collides with a replace of mepc in the same cycle.
    task automatic do_trap(input logic irq, input logic [3:0] code, input logic [31:0] pc,
                           input logic collide);
        @(negedge clk);
        trap_take = 1'b1; trap_irq = irq; trap_code = code; trap_pc = pc;
        if (collide) begin
            csr_en = 1'b1; csr_addr = 12'h341; csr_op = WR; csr_wdata = 32'h0000_5550;
        end
        @(posedge clk);
        #1;
        trap_take = 1'b0; csr_en = 1'b0; csr_op = 2'b00;
    endtask

    task automatic do_mret();
        @(negedge clk);
        mret_take = 1'b1;
        @(posedge clk);
        #1;
        mret_take = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // reset state
        rd(12'h300, 32'h0000_1800, "R3 reset mstatus");
        rd(12'h304, 32'h0, "R3 reset mie");
        rd(12'h305, 32'h0, "R2 reset mtvec");

        // replace / set / clear on mscratch
        access(12'h340, WR, 32'hDEAD_BEEF, 1'b1, 32'h0, 1'b0, "R1 replace old");
        rd(12'h340, 32'hDEAD_BEEF, "R1 replace new");
        access(12'h340, ST, 32'h0000_0010, 1'b1, 32'hDEAD_BEEF, 1'b0, "R1 set old");
        rd(12'h340, 32'hDEAD_BEFF, "R1 set new");
        access(12'h340, CL, 32'hFF00_0000, 1'b1, 32'hDEAD_BEFF, 1'b0, "R1 clear old");
        rd(12'h340, 32'h00AD_BEFF, "R1 clear new");

        // alignment of mtvec / mepc
        access(12'h305, WR, 32'h8000_0103, 1'b1, 32'h0, 1'b0, "R2 mtvec write");
        e_vec = 32'h8000_0100;
        rd(12'h305, 32'h8000_0100, "R2 mtvec aligned");
        access(12'h341, WR, 32'h0000_1003, 1'b1, 32'h0, 1'b0, "R2 mepc write");
        e_ret = 32'h0000_1000;
        rd(12'h341, 32'h0000_1000, "R2 mepc aligned");

        // identity group
        rd(12'hF11, 32'h0, "R8 ident zero-mask read");
        access(12'hF11, WR, 32'h1, 1'b1, 32'h0, 1'b1, "R6 ident replace illegal");
        access(12'hF14, CL, 32'h4, 1'b1, 32'h0, 1'b1, "R6 ident clear illegal");
        access(12'hF15, CL, 32'h0, 1'b1, 32'h0, 1'b0, "R8 ident zero-mask clear legal");

        // silent read-zero group
        access(12'hB00, WR, 32'h5, 1'b1, 32'h0, 1'b0, "R5 counter write legal");
        rd(12'hB00, 32'h0, "R5 counter still zero");
        access(12'hB11, WR, 32'hFFFF, 1'b1, 32'h0, 1'b0, "R5 hpm counter write legal");
        rd(12'hB11, 32'h0, "R5 hpm counter zero");
        rd(12'h329, 32'h0, "R5 event selector zero");
        access(12'h343, WR, 32'h7, 1'b1, 32'h0, 1'b0, "R5 tval write legal");
        rd(12'h343, 32'h0, "R5 tval zero");

        // unimplemented
        rd_ill: begin
            access(12'h302, ST, 32'h0, 1'b1, 32'h0, 1'b1, "R7 deleg illegal");
            access(12'h34B, ST, 32'h0, 1'b1, 32'h0, 1'b1, "R7 tval2 illegal");
            access(12'h7C0, ST, 32'h0, 1'b1, 32'h0, 1'b1, "R7 unlisted illegal");
            access(12'hF16, ST, 32'h0, 1'b1, 32'h0, 1'b1, "R7 past ident illegal");
            access(12'h747, ST, 32'h0, 1'b1, 32'h0, 1'b1, "R7 seccfg illegal");
            access(12'h302, WR, 32'h1, 1'b0, 32'h0, 1'b0, "R7 idle not illegal");
        end

        // mstatus / mie field masks
        access(12'h300, WR, 32'hFFFF_FFFF, 1'b1, 32'h0000_1800, 1'b0, "R3 mstatus write");
        rd(12'h300, 32'h0000_1888, "R3 mstatus fields");
        access(12'h304, WR, 32'hFFFF_FFFF, 1'b1, 32'h0, 1'b0, "R3 mie write");
        rd(12'h304, 32'h0000_0800, "R3 mie field");

        // mip and pending
        access(12'h344, WR, 32'h0, 1'b1, 32'h0, 1'b0, "R4 mip write legal");
        @(negedge clk) ext_irq = 1'b1;
        e_irq = 1'b1;
        rd(12'h344, 32'h0000_0800, "R4 mip reflects source R11");
        access(12'h344, CL, 32'hFFFF_FFFF, 1'b1, 32'h0000_0800, 1'b0, "R4 mip clear ignored");
        rd(12'h344, 32'h0000_0800, "R4 mip unchanged");
        access(12'h304, CL, 32'h0000_0800, 1'b1, 32'h0000_0800, 1'b0, "R11 mask by mie");
        e_irq = 1'b0;
        rd(12'h304, 32'h0, "R11 masked no pending");
        access(12'h304, ST, 32'h0000_0800, 1'b1, 32'h0, 1'b0, "R11 unmask");
        e_irq = 1'b1;
        rd(12'h344, 32'h0000_0800, "R11 pending again");

        // interrupt trap colliding with mepc write
        do_trap(1'b1, 4'd11, 32'h0000_0124, 1'b1);
        e_irq = 1'b0;
        e_ret = 32'h0000_0124;
        rd(12'h342, 32'h8000_000B, "R9 mcause interrupt");
        rd(12'h300, 32'h0000_1880, "R9 mstatus after trap");
        rd(12'h341, 32'h0000_0124, "R12 trap beats csr write");

        do_mret();
        e_irq = 1'b1;
        rd(12'h300, 32'h0000_1888, "R10 mstatus after mret");

        // exception trap with MIE clear
        access(12'h300, CL, 32'h0000_0008, 1'b1, 32'h0000_1888, 1'b0, "R11 clear global enable");
        e_irq = 1'b0;
        rd(12'h300, 32'h0000_1880, "R11 global masked");
        do_trap(1'b0, 4'd2, 32'h0000_0200, 1'b0);
        e_ret = 32'h0000_0200;
        rd(12'h300, 32'h0000_1800, "R9 mstatus after exception");
        rd(12'h342, 32'h0000_0002, "R9 mcause exception");
        do_mret();
        rd(12'h300, 32'h0000_1880, "R10 mret restores clear MIE");

        repeat (3) @(posedge clk);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard R1: got %0d pending, exp 0", sb_q.size());
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule